// File: doc/BRIEF.md
# Feature Parameter Block Scanner

This block is given the byte address of an extended (version 1) feature header in device register space. It fetches the two words that follow the GUID, which tell where the feature's own registers live and how large they are. It turns the register pointer into a byte address, which can be absolute or taken relative to the header. When the header says it carries parameters, the scanner follows the chain of parameter blocks that starts right after those words. For every block it emits one record with the parameter's ID, version, first data byte address and data length in bytes.

All memory traffic goes through a single read port that allows one outstanding read. The scanner raises a request for one cycle with an address and then waits for the matching data-valid. A scan runs until a block marked as the last one, or until a broken link stops it with an error. A start pulse that arrives while a scan is running has no effect.

Top module: `fps_scanner`

## Requirements
- R1: After a start, the first read goes to header+0x18 and the second to header+0x20. There is never more than one read outstanding: no new request is made until the data-valid for the previous one has arrived.
- R2: When bit 0 of the +0x18 word is 1 (absolute), reg_abs_o is 1 and reg_addr_o is bits 63:1 of that word shifted left by one, truncated to AW bits.
- R3: When bit 0 of the +0x18 word is 0 (relative), reg_abs_o is 0 and reg_addr_o is the header address plus bits 63:1 of that word shifted left by one, modulo 2^AW.
- R4: The fields of the +0x20 word are reported in the single-cycle reg_vld_o pulse: size from bits 63:32, parameter flag from bit 31, group from bits 30:16 and instance from bits 15:0. This pulse comes before any parameter record.
- R5: If the parameter flag (bit 31) is 0, done_o pulses in the same cycle as reg_vld_o. No further read is made and no parameter record is emitted.
- R6: The first parameter header is read at header+0x28. Each record carries the ID from bits 15:0 and the version from bits 31:16, and its data address is that parameter header's address plus 8.
- R7: The next parameter header is read at the current one's address plus 8 times its next field (bits 63:35), modulo 2^AW.
- R8: A record's data length is (next-1)*8 bytes, or 0 when next is 0.
- R9: A parameter header with bit 32 (end of parameters) set is reported, and done_o pulses in the same cycle as that record.
- R10: A parameter header whose next field is 0 and whose bit 32 is 0 emits no record. err_o and done_o pulse together and the scan ends.
- R11: start_i is ignored while busy_o is 1. It changes neither the reads nor the records of the running scan.
- R12: busy_o rises the cycle after an accepted start and falls in the cycle done_o pulses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Start a scan (accepted when idle) |
| hdr_addr_i | input | AW | Byte address of the feature header |
| busy_o | output | 1 | Scan in progress |
| rd_req_o | output | 1 | One-cycle read request |
| rd_addr_o | output | AW | Read byte address |
| rd_valid_i | input | 1 | Read data valid |
| rd_data_i | input | 64 | Read data word |
| reg_vld_o | output | 1 | Register location record valid |
| reg_abs_o | output | 1 | Register pointer was absolute |
| reg_addr_o | output | AW | Resolved register byte address |
| reg_size_o | output | 32 | Register set size in bytes |
| reg_has_prm_o | output | 1 | Header announces parameters |
| reg_group_o | output | 15 | Group ID |
| reg_inst_o | output | 16 | Instance ID |
| prm_vld_o | output | 1 | Parameter record valid |
| prm_id_o | output | 16 | Parameter ID |
| prm_ver_o | output | 16 | Parameter version |
| prm_addr_o | output | AW | First data byte address |
| prm_len_o | output | 32 | Data length in bytes |
| done_o | output | 1 | Scan finished (pulse) |
| err_o | output | 1 | Scan stopped on a broken link (pulse) |

## Verification
The bench builds the scanner with AW=16, which is narrower than the default. Relative pointers and parameter links can then wrap past the top of the address space, so the modulo rules of R3 and R7 are exercised. The memory model returns each read after a random 0 to 3 cycle delay, which keeps the one-outstanding rule under stress. Random chains of up to six blocks are mixed with directed cases for no parameters, an end block with a zero link, an early broken link, and a start pulse in the middle of a scan.

// File: rtl/fps_pkg.sv
package fps_pkg;
    localparam int WORD_W = 64;
    localparam int LEN_W  = 32;
    localparam int NXT_W  = 29;

    localparam logic [7:0] OFF_LOC  = 8'h18;
    localparam logic [7:0] OFF_SIZE = 8'h20;
    localparam logic [7:0] OFF_PRM  = 8'h28;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_WLOC,
        ST_WSIZE,
        ST_WPRM
    } scan_st_e;
endpackage

// File: rtl/fps_rd_port.sv
module fps_rd_port #(
    parameter int AW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          issue_i,
    input  logic [AW-1:0] issue_addr_i,
    input  logic          rd_valid_i,
    output logic          rd_req_o,
    output logic [AW-1:0] rd_addr_o
);
    typedef struct packed {
        logic          req;
        logic          pend;
        logic [AW-1:0] addr;
    } port_t;

    port_t p_d, p_q;

    always_comb begin
        p_d      = p_q;
        p_d.req  = issue_i;
        p_d.pend = issue_i | (p_q.pend & ~rd_valid_i);
        if (issue_i) p_d.addr = issue_addr_i;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) p_q <= '0;
        else        p_q <= p_d;
    end

    assign rd_req_o  = p_q.req;
    assign rd_addr_o = p_q.addr;

    // a read still waiting for its data blocks any new request
    assert_single_outstanding_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (p_q.pend && !rd_valid_i) |-> !issue_i);
endmodule

// File: rtl/fps_loc_decode.sv
module fps_loc_decode #(
    parameter int AW = 32
) (
    input  logic [AW-1:0] hdr_i,
    input  logic [63:0]   loc_word_i,
    input  logic [63:0]   size_word_i,
    output logic          abs_o,
    output logic [AW-1:0] addr_o,
    output logic [31:0]   size_o,
    output logic          has_prm_o,
    output logic [14:0]   group_o,
    output logic [15:0]   inst_o
);
    logic [63:0] ptr;

    always_comb begin
        ptr       = {loc_word_i[63:1], 1'b0};
        abs_o     = loc_word_i[0];
        addr_o    = abs_o ? ptr[AW-1:0] : hdr_i + ptr[AW-1:0];
        size_o    = size_word_i[63:32];
        has_prm_o = size_word_i[31];
        group_o   = size_word_i[30:16];
        inst_o    = size_word_i[15:0];
    end
endmodule

// File: rtl/fps_prm_decode.sv
module fps_prm_decode #(
    parameter int AW = 32
) (
    input  logic [AW-1:0]              cur_i,
    input  logic [fps_pkg::NXT_W-1:0]  nxt_i,
    input  logic                       eop_i,
    output logic [AW-1:0]              data_addr_o,
    output logic [AW-1:0]              next_addr_o,
    output logic [fps_pkg::LEN_W-1:0]  len_o,
    output logic                       bad_o
);
    import fps_pkg::*;

    logic [LEN_W-1:0] step;

    always_comb begin
        step        = {nxt_i, 3'b000};
        data_addr_o = cur_i + AW'(8);
        next_addr_o = cur_i + step[AW-1:0];
        len_o       = (nxt_i == '0) ? '0 : {nxt_i - NXT_W'(1), 3'b000};
        bad_o       = (nxt_i == '0) && !eop_i;
    end
endmodule

// File: rtl/fps_scanner.sv
module fps_scanner #(
    parameter int AW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start_i,
    input  logic [AW-1:0] hdr_addr_i,
    output logic          busy_o,
    output logic          rd_req_o,
    output logic [AW-1:0] rd_addr_o,
    input  logic          rd_valid_i,
    input  logic [63:0]   rd_data_i,
    output logic          reg_vld_o,
    output logic          reg_abs_o,
    output logic [AW-1:0] reg_addr_o,
    output logic [31:0]   reg_size_o,
    output logic          reg_has_prm_o,
    output logic [14:0]   reg_group_o,
    output logic [15:0]   reg_inst_o,
    output logic          prm_vld_o,
    output logic [15:0]   prm_id_o,
    output logic [15:0]   prm_ver_o,
    output logic [AW-1:0] prm_addr_o,
    output logic [31:0]   prm_len_o,
    output logic          done_o,
    output logic          err_o
);
    import fps_pkg::*;

    typedef struct packed {
        scan_st_e      st;
        logic          busy;
        logic [AW-1:0] hdr;
        logic [AW-1:0] cur;
        logic          reg_vld;
        logic          reg_abs;
        logic [AW-1:0] reg_addr;
        logic [31:0]   reg_size;
        logic          reg_has_prm;
        logic [14:0]   reg_group;
        logic [15:0]   reg_inst;
        logic          prm_vld;
        logic [15:0]   prm_id;
        logic [15:0]   prm_ver;
        logic [AW-1:0] prm_addr;
        logic [31:0]   prm_len;
        logic          done;
        logic          err;
    } scan_t;

    scan_t s_d, s_q;

    logic          issue;
    logic [AW-1:0] issue_addr;

    logic          loc_abs, loc_has_prm;
    logic [AW-1:0] loc_addr;
    logic [31:0]   loc_size;
    logic [14:0]   loc_group;
    logic [15:0]   loc_inst;

    logic [AW-1:0]    pd_data_addr, pd_next_addr;
    logic [LEN_W-1:0] pd_len;
    logic             pd_bad;

    fps_rd_port #(.AW(AW)) u_port (
        .clk          (clk),
        .rst_n        (rst_n),
        .issue_i      (issue),
        .issue_addr_i (issue_addr),
        .rd_valid_i   (rd_valid_i),
        .rd_req_o     (rd_req_o),
        .rd_addr_o    (rd_addr_o)
    );

    // the pointer word is latched into reg_abs/reg_addr before the size word arrives
    fps_loc_decode #(.AW(AW)) u_loc (
        .hdr_i       (s_q.hdr),
        .loc_word_i  (rd_data_i),
        .size_word_i (rd_data_i),
        .abs_o       (loc_abs),
        .addr_o      (loc_addr),
        .size_o      (loc_size),
        .has_prm_o   (loc_has_prm),
        .group_o     (loc_group),
        .inst_o      (loc_inst)
    );

    fps_prm_decode #(.AW(AW)) u_prm (
        .cur_i       (s_q.cur),
        .nxt_i       (rd_data_i[63:35]),
        .eop_i       (rd_data_i[32]),
        .data_addr_o (pd_data_addr),
        .next_addr_o (pd_next_addr),
        .len_o       (pd_len),
        .bad_o       (pd_bad)
    );

    always_comb begin
        s_d         = s_q;
        s_d.reg_vld = 1'b0;
        s_d.prm_vld = 1'b0;
        s_d.done    = 1'b0;
        s_d.err     = 1'b0;
        issue       = 1'b0;
        issue_addr  = '0;

        unique case (s_q.st)
            ST_IDLE: begin
                if (start_i) begin
                    s_d.hdr    = hdr_addr_i;
                    s_d.busy   = 1'b1;
                    s_d.st     = ST_WLOC;
                    issue      = 1'b1;
                    issue_addr = hdr_addr_i + AW'(OFF_LOC);
                end
            end
            ST_WLOC: begin
                if (rd_valid_i) begin
                    s_d.reg_abs  = loc_abs;
                    s_d.reg_addr = loc_addr;
                    s_d.st       = ST_WSIZE;
                    issue        = 1'b1;
                    issue_addr   = s_q.hdr + AW'(OFF_SIZE);
                end
            end
            ST_WSIZE: begin
                if (rd_valid_i) begin
                    s_d.reg_vld     = 1'b1;
                    s_d.reg_size    = loc_size;
                    s_d.reg_has_prm = loc_has_prm;
                    s_d.reg_group   = loc_group;
                    s_d.reg_inst    = loc_inst;
                    if (loc_has_prm) begin
                        s_d.cur    = s_q.hdr + AW'(OFF_PRM);
                        s_d.st     = ST_WPRM;
                        issue      = 1'b1;
                        issue_addr = s_q.hdr + AW'(OFF_PRM);
                    end else begin
                        s_d.done = 1'b1;
                        s_d.busy = 1'b0;
                        s_d.st   = ST_IDLE;
                    end
                end
            end
            ST_WPRM: begin
                if (rd_valid_i) begin
                    if (pd_bad) begin
                        s_d.err  = 1'b1;
                        s_d.done = 1'b1;
                        s_d.busy = 1'b0;
                        s_d.st   = ST_IDLE;
                    end else begin
                        s_d.prm_vld  = 1'b1;
                        s_d.prm_id   = rd_data_i[15:0];
                        s_d.prm_ver  = rd_data_i[31:16];
                        s_d.prm_addr = pd_data_addr;
                        s_d.prm_len  = pd_len;
                        if (rd_data_i[32]) begin
                            s_d.done = 1'b1;
                            s_d.busy = 1'b0;
                            s_d.st   = ST_IDLE;
                        end else begin
                            s_d.cur    = pd_next_addr;
                            issue      = 1'b1;
                            issue_addr = pd_next_addr;
                        end
                    end
                end
            end
            default: s_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q    <= '0;
            s_q.st <= ST_IDLE;
        end else begin
            s_q <= s_d;
        end
    end

    assign busy_o        = s_q.busy;
    assign reg_vld_o     = s_q.reg_vld;
    assign reg_abs_o     = s_q.reg_abs;
    assign reg_addr_o    = s_q.reg_addr;
    assign reg_size_o    = s_q.reg_size;
    assign reg_has_prm_o = s_q.reg_has_prm;
    assign reg_group_o   = s_q.reg_group;
    assign reg_inst_o    = s_q.reg_inst;
    assign prm_vld_o     = s_q.prm_vld;
    assign prm_id_o      = s_q.prm_id;
    assign prm_ver_o     = s_q.prm_ver;
    assign prm_addr_o    = s_q.prm_addr;
    assign prm_len_o     = s_q.prm_len;
    assign done_o        = s_q.done;
    assign err_o         = s_q.err;

    assert_flagless_ends_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_vld_o && !reg_has_prm_o) |-> (done_o && !prm_vld_o));

    assert_record_in_scan_R6: assert property (@(posedge clk) disable iff (!rst_n)
        prm_vld_o |-> $past(busy_o));

    assert_broken_link_R10: assert property (@(posedge clk) disable iff (!rst_n)
        err_o |-> (done_o && !prm_vld_o));

    assert_busy_drops_R12: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> !busy_o);

    assert_start_held_off_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && start_i) |=> (s_q.hdr == $past(s_q.hdr)));
endmodule

// File: tb/sim_fps_scanner.sv
module sim_fps_scanner;
    localparam int AW = 16;
    localparam int MW = 2048;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start_i = 1'b0;
    logic [AW-1:0] hdr_addr_i = '0;
    logic          busy_o, rd_req_o, rd_valid_i;
    logic [AW-1:0] rd_addr_o;
    logic [63:0]   rd_data_i;
    logic          reg_vld_o, reg_abs_o, reg_has_prm_o;
    logic [AW-1:0] reg_addr_o;
    logic [31:0]   reg_size_o;
    logic [14:0]   reg_group_o;
    logic [15:0]   reg_inst_o;
    logic          prm_vld_o;
    logic [15:0]   prm_id_o, prm_ver_o;
    logic [AW-1:0] prm_addr_o;
    logic [31:0]   prm_len_o;
    logic          done_o, err_o;

    always #4 clk = ~clk;

    fps_scanner #(.AW(AW)) u0 (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .hdr_addr_i(hdr_addr_i),
        .busy_o(busy_o), .rd_req_o(rd_req_o), .rd_addr_o(rd_addr_o),
        .rd_valid_i(rd_valid_i), .rd_data_i(rd_data_i),
        .reg_vld_o(reg_vld_o), .reg_abs_o(reg_abs_o), .reg_addr_o(reg_addr_o),
        .reg_size_o(reg_size_o), .reg_has_prm_o(reg_has_prm_o),
        .reg_group_o(reg_group_o), .reg_inst_o(reg_inst_o),
        .prm_vld_o(prm_vld_o), .prm_id_o(prm_id_o), .prm_ver_o(prm_ver_o),
        .prm_addr_o(prm_addr_o), .prm_len_o(prm_len_o),
        .done_o(done_o), .err_o(err_o)
    );

    int n_run = 0;
    int n_fail = 0;

    logic [63:0] mem [MW];

    function automatic int idx(input logic [AW-1:0] a);
        return int'(a[13:3]);
    endfunction

    // memory responder and output monitor
    logic          pend = 1'b0;
    int            lat = 0;
    logic [AW-1:0] paddr = '0;
    logic          overlap = 1'b0;
    int            n_rd = 0;
    logic [AW-1:0] rd_log [16];
    int            n_rec = 0;
    logic [15:0]   g_id [8];
    logic [15:0]   g_ver [8];
    logic [AW-1:0] g_addr [8];
    logic [31:0]   g_len [8];
    int            n_regv = 0;
    logic          g_abs, g_hasp;
    logic [AW-1:0] g_raddr;
    logic [31:0]   g_size;
    logic [14:0]   g_grp;
    logic [15:0]   g_inst;
    logic          seen_done = 1'b0, seen_err = 1'b0, rec_after_reg_ok = 1'b1;

    initial begin
        rd_valid_i = 1'b0;
        rd_data_i  = '0;
    end

    always @(negedge clk) begin
        rd_valid_i = 1'b0;
        if (pend) begin
            if (lat == 0) begin
                rd_valid_i = 1'b1;
                rd_data_i  = mem[idx(paddr)];
                pend = 1'b0;
            end else lat = lat - 1;
        end
        if (rd_req_o) begin
            if (pend) overlap = 1'b1;
            pend  = 1'b1;
            paddr = rd_addr_o;
            lat   = int'($urandom % 4);
            if (n_rd < 16) rd_log[n_rd] = rd_addr_o;
            n_rd++;
        end
        if (reg_vld_o) begin
            n_regv++;
            g_abs = reg_abs_o; g_raddr = reg_addr_o; g_size = reg_size_o;
            g_hasp = reg_has_prm_o; g_grp = reg_group_o; g_inst = reg_inst_o;
        end
        if (prm_vld_o) begin
            if (n_regv == 0) rec_after_reg_ok = 1'b0;
            if (n_rec < 8) begin
                g_id[n_rec] = prm_id_o; g_ver[n_rec] = prm_ver_o;
                g_addr[n_rec] = prm_addr_o; g_len[n_rec] = prm_len_o;
            end
            n_rec++;
        end
        if (done_o) seen_done = 1'b1;
        if (err_o)  seen_err  = 1'b1;
    end

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // expected values of the current scan
    logic [AW-1:0] e_hdr;
    logic          e_abs, e_hasp, e_err;
    logic [AW-1:0] e_raddr;
    logic [31:0]   e_size;
    logic [14:0]   e_grp;
    logic [15:0]   e_inst;
    int            e_n;
    int            e_nrd;
    logic [AW-1:0] e_rd [16];
    logic [15:0]   e_id [8];
    logic [15:0]   e_ver [8];
    logic [AW-1:0] e_addr [8];
    logic [31:0]   e_len [8];

    // nprm: blocks in chain; bad_at: index of broken link or -1; last_nxt: next on the end block
    task automatic build(input logic [AW-1:0] hdr, input logic abs, input logic [62:0] fld,
                         input logic hasp, input int nprm, input int bad_at, input int last_nxt);
        logic [63:0]   ptr;
        logic [AW-1:0] cur;
        logic [28:0]   nx;
        logic          eop;
        logic [15:0]   id, ver;
        e_hdr  = hdr;
        e_abs  = abs;
        ptr    = {fld, 1'b0};
        e_raddr = abs ? ptr[AW-1:0] : hdr + ptr[AW-1:0];
        e_size = $urandom;
        e_grp  = 15'($urandom);
        e_inst = 16'($urandom);
        e_hasp = hasp;
        e_err  = 1'b0;
        mem[idx(hdr + 16'h18)] = {fld, abs};
        mem[idx(hdr + 16'h20)] = {e_size, hasp, e_grp, e_inst};
        e_rd[0] = hdr + 16'h18;
        e_rd[1] = hdr + 16'h20;
        e_nrd = 2;
        e_n = 0;
        if (hasp) begin
            cur = hdr + 16'h28;
            for (int i = 0; i < nprm; i++) begin
                id  = 16'($urandom);
                ver = 16'($urandom);
                eop = (i == nprm - 1);
                if (i == bad_at) begin nx = '0; eop = 1'b0; end
                else if (eop) nx = 29'(last_nxt);
                else nx = 29'(1 + $urandom % 4);
                mem[idx(cur)] = {nx, 2'b11, eop, ver, id};
                e_rd[e_nrd] = cur; e_nrd++;
                if (i == bad_at) begin e_err = 1'b1; break; end
                e_id[e_n] = id; e_ver[e_n] = ver; e_addr[e_n] = cur + 16'd8;
                e_len[e_n] = (nx == 0) ? 32'd0 : 32'((nx - 1) * 8);
                e_n++;
                if (eop) break;
                cur = cur + 16'(nx * 8);
            end
        end
    endtask

    task automatic run_scan(input bit poke);
        n_rd = 0; n_rec = 0; n_regv = 0; overlap = 1'b0;
        seen_done = 1'b0; seen_err = 1'b0; rec_after_reg_ok = 1'b1;
        @(negedge clk);
        start_i = 1'b1; hdr_addr_i = e_hdr;
        @(negedge clk);
        start_i = 1'b0; hdr_addr_i = ~e_hdr;
        chk(busy_o === 1'b1, "R12 busy after start", longint'(busy_o), 1);
        if (poke) begin
            repeat (3) @(negedge clk);
            start_i = 1'b1;
            @(negedge clk);
            start_i = 1'b0;
        end
        for (int t = 0; t < 3000 && !seen_done; t++) @(negedge clk);
        chk(seen_done, "R9 scan finished (watchdog)", longint'(seen_done), 1);
        chk(busy_o === 1'b0, "R12 busy after done", longint'(busy_o), 0);
        chk(!overlap, "R1 single outstanding read", longint'(overlap), 0);
        chk(n_rd == e_nrd, "R7 read count", n_rd, e_nrd);
        for (int i = 0; i < e_nrd && i < n_rd && i < 16; i++)
            chk(rd_log[i] == e_rd[i], (i < 2) ? "R1 header read address" : "R7 link address",
                longint'(rd_log[i]), longint'(e_rd[i]));
        chk(n_regv == 1, "R4 one location record", n_regv, 1);
        chk(g_abs == e_abs, "R2 absolute flag", longint'(g_abs), longint'(e_abs));
        chk(g_raddr == e_raddr, e_abs ? "R2 absolute address" : "R3 relative address",
            longint'(g_raddr), longint'(e_raddr));
        chk({g_size, g_hasp, g_grp, g_inst} == {e_size, e_hasp, e_grp, e_inst},
            "R4 size/flag/group/instance", longint'({g_size, g_hasp, g_grp, g_inst}),
            longint'({e_size, e_hasp, e_grp, e_inst}));
        chk(rec_after_reg_ok, "R4 location before parameters", longint'(rec_after_reg_ok), 1);
        chk(n_rec == e_n, e_hasp ? "R9 record count" : "R5 no records", n_rec, e_n);
        for (int i = 0; i < e_n && i < n_rec; i++) begin
            chk({g_id[i], g_ver[i]} == {e_id[i], e_ver[i]}, "R6 id/version",
                longint'({g_id[i], g_ver[i]}), longint'({e_id[i], e_ver[i]}));
            chk(g_addr[i] == e_addr[i], "R6 data address", longint'(g_addr[i]), longint'(e_addr[i]));
            chk(g_len[i] == e_len[i], "R8 data length", longint'(g_len[i]), longint'(e_len[i]));
        end
        chk(seen_err == e_err, "R10 error flag", longint'(seen_err), longint'(e_err));
    endtask

    initial begin
        void'($urandom(32'h5EED_0042));
        for (int i = 0; i < MW; i++) mem[i] = '0;
        repeat (3) @(negedge clk);
        chk(busy_o === 1'b0 && rd_req_o === 1'b0, "R12 reset idle", longint'({busy_o, rd_req_o}), 0);
        chk(done_o === 1'b0 && err_o === 1'b0, "R10 reset flags", longint'({done_o, err_o}), 0);
        rst_n = 1'b1;

        // R5: no parameters
        build(16'h0100, 1'b1, 63'h1234_5678_9ABC, 1'b0, 0, -1, 0);
        run_scan(1'b0);
        // R3: relative pointer wrapping past 2^AW
        build(16'h0100, 1'b0, {47'h0, 16'h7F80}, 1'b1, 2, -1, 3);
        run_scan(1'b0);
        // R8: end block with zero next
        build(16'h0800, 1'b1, 63'h77, 1'b1, 1, -1, 0);
        run_scan(1'b0);
        // R10: broken link in the middle
        build(16'h0400, 1'b0, 63'h10, 1'b1, 4, 2, 2);
        run_scan(1'b0);
        // R10: broken link on the first block
        build(16'h0600, 1'b1, 63'h20, 1'b1, 3, 0, 1);
        run_scan(1'b0);
        // R11: start pulse mid-scan
        build(16'h0A00, 1'b0, 63'h40, 1'b1, 3, -1, 2);
        run_scan(1'b1);

        for (int k = 0; k < 40; k++) begin
            build(16'({$urandom % 1536, 3'b000}), 1'($urandom), {$urandom, $urandom},
                  1'($urandom % 4 != 0), 1 + int'($urandom % 6),
                  ($urandom % 5 == 0) ? int'($urandom % 6) : -1, int'($urandom % 5));
            run_scan(k % 7 == 3);
        end

        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule